// File: doc/BRIEF.md
# Serial Link Receive Flow Controller

This block sits behind the line decoder of a serial point-to-point link. It accepts one decoded word per cycle, flagged as either a payload word or a control word. Payload words go into a receive FIFO. From there they leave on a parallel output port, one per cycle, while the downstream side asserts neither its suspend input nor its not-ready input. Control words carry sideband bits that the far end sends across the link. The not-ready, direction and two general-purpose bits bypass the FIFO and reach their output registers one edge after the control word arrives, with no alignment to the payload stream. The sync bit instead marks the next payload word accepted into the FIFO, so it leaves the port together with that word.

The block also works out a back-off flag from its own FIFO occupancy, with hysteresis between two programmable thresholds. The local transmit side uses this flag to tell the remote node to pause. It is never taken from the downstream suspend input. A payload word that arrives while the FIFO is full is dropped, and a sticky overflow flag records the loss.

Top module: `lnk_rx_flow`

## Requirements
- R1: Payload words leave the port in the order they were accepted, each exactly once, with no word lost while the FIFO has room.
- R2: `px_valid` is high only when the FIFO holds a word and both `dn_suspend` and `dn_notready` are low. The word shown on `px_data` is removed at the edge that ends that cycle.
- R3: A control word (`lnk_ctrl`=1) is never stored as payload. Its fields sit at fixed bit positions: bit0 is not-ready, bit1 is direction, bit2 is sync, bit3 is general-purpose 0 and bit4 is general-purpose 1.
- R4: `sb_notready`, `sb_dir` and `sb_gp` take the fields of a control word at the next clock edge, even while payload words are still waiting in the FIFO.
- R5: A control word with the sync field set marks the next payload word accepted. `px_sync` is high exactly while that word is on the port.
- R6: `backoff` becomes 1 one edge after occupancy is at or above `cfg_hi`, becomes 0 one edge after occupancy is below `cfg_lo`, and holds its value in between. It does not depend on `dn_suspend`. `cfg_hi` must be greater than `cfg_lo`.
- R7: A payload word that arrives while the FIFO holds DEPTH words is dropped, even if a word leaves in the same cycle. `overflow` then goes to 1 and stays there until reset.
- R8: After reset, `px_valid`, `px_sync`, `backoff`, `overflow` and all sideband outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_valid | input | 1 | Decoded word present |
| lnk_ctrl | input | 1 | 1: control word, 0: payload word |
| lnk_word | input | DW | Decoded word |
| dn_suspend | input | 1 | Downstream suspend request |
| dn_notready | input | 1 | Downstream not-ready |
| cfg_hi | input | CW | Back-off assert threshold |
| cfg_lo | input | CW | Back-off release threshold |
| px_data | output | DW | Output payload word |
| px_valid | output | 1 | Output word valid strobe |
| px_sync | output | 1 | Output word carries sync mark |
| sb_notready | output | 1 | Last received remote not-ready |
| sb_dir | output | 1 | Last received direction |
| sb_gp | output | 2 | Last received general-purpose bits |
| backoff | output | 1 | Back-off request toward remote node |
| overflow | output | 1 | Sticky dropped-word flag |

## Verification
The bench builds the block with DW=16 and DEPTH=16 and sets the thresholds to 10 and 4. This small FIFO lets it fill completely, so the full-FIFO drop and the sticky overflow flag are within reach in a few dozen cycles. The thresholds leave a band of six entries in which the bench can step occupancy one word at a time and watch back-off rise, hold and fall. A long phase with random suspend and not-ready patterns and scattered sync control words then checks ordering and sync placement against a scoreboard.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
    localparam int CTRL_W = 5;
    typedef struct packed {
        logic gp1;
        logic gp0;
        logic sync;
        logic dir;
        logic notready;
    } ctrl_t;
endpackage

// File: rtl/lrf_fifo.sv
module lrf_fifo #(
    parameter int EW    = 33,
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_data,
    input  logic          rd_en,
    output logic [EW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } st_t;

    st_t s_q, s_d;
    logic full, do_wr, do_rd;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign drop    = wr_en && full;
    assign rd_data = s_q.mem[s_q.rp];
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (do_wr) begin
            s_d.mem[s_q.wp] = wr_data;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_rd)
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        case ({do_wr, do_rd})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.wp  <= '0;
            s_q.rp  <= '0;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1: occupancy never exceeds DEPTH
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R7: a write into a full FIFO leaves the count unchanged or lower
    a_r7_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> s_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/lrf_sideband.sv
module lrf_sideband
    import lrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  ctrl_t      fields,
    output logic       notready,
    output logic       dir,
    output logic [1:0] gp
);
    typedef struct packed {
        logic       nr;
        logic       dr;
        logic [1:0] gp;
    } sb_t;

    sb_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.nr = fields.notready;
            r_d.dr = fields.dir;
            r_d.gp = {fields.gp1, fields.gp0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign notready = r_q.nr;
    assign dir      = r_q.dr;
    assign gp       = r_q.gp;

    // R4: without a control word the sideband registers hold
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(r_q));
endmodule

// File: rtl/lrf_backoff.sv
module lrf_backoff #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    output logic          backoff
);
    logic bo_q, bo_d;

    always_comb begin
        bo_d = bo_q;
        if (level >= hi)     bo_d = 1'b1;
        else if (level < lo) bo_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bo_q <= 1'b0;
        else        bo_q <= bo_d;
    end

    assign backoff = bo_q;

    // R6: rise at or above the high mark, fall below the low mark
    a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= hi) |=> backoff);
    a_r6_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (level < lo && level < hi) |=> !backoff);
endmodule

// File: rtl/lnk_rx_flow.sv
module lnk_rx_flow
    import lrf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lnk_valid,
    input  logic          lnk_ctrl,
    input  logic [DW-1:0] lnk_word,
    input  logic          dn_suspend,
    input  logic          dn_notready,
    input  logic [CW-1:0] cfg_hi,
    input  logic [CW-1:0] cfg_lo,
    output logic [DW-1:0] px_data,
    output logic          px_valid,
    output logic          px_sync,
    output logic          sb_notready,
    output logic          sb_dir,
    output logic [1:0]    sb_gp,
    output logic          backoff,
    output logic          overflow
);
    typedef struct packed {
        logic sync_pend;
        logic ovf;
    } top_t;

    top_t t_q, t_d;
    ctrl_t cw;
    logic data_in, ctrl_in, f_empty, f_drop;
    logic [DW:0] f_rd;
    logic [CW-1:0] f_cnt;

    assign cw      = ctrl_t'(lnk_word[CTRL_W-1:0]);
    assign data_in = lnk_valid && !lnk_ctrl;
    assign ctrl_in = lnk_valid && lnk_ctrl;

    lrf_fifo #(.EW(DW + 1), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_in),
        .wr_data ({t_q.sync_pend, lnk_word}),
        .rd_en   (px_valid),
        .rd_data (f_rd),
        .count   (f_cnt),
        .empty   (f_empty),
        .drop    (f_drop)
    );

    lrf_sideband u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctrl_in),
        .fields   (cw),
        .notready (sb_notready),
        .dir      (sb_dir),
        .gp       (sb_gp)
    );

    lrf_backoff #(.CW(CW)) u_bo (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (f_cnt),
        .hi      (cfg_hi),
        .lo      (cfg_lo),
        .backoff (backoff)
    );

    always_comb begin
        t_d = t_q;
        if (ctrl_in && cw.sync)         t_d.sync_pend = 1'b1;
        else if (data_in && !f_drop)    t_d.sync_pend = 1'b0;
        if (f_drop)                     t_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign px_valid = !f_empty && !dn_suspend && !dn_notready;
    assign px_data  = f_rd[DW-1:0];
    assign px_sync  = px_valid && f_rd[DW];
    assign overflow = t_q.ovf;

    // R2: strobe only when the downstream side allows it
    a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |-> (!dn_suspend && !dn_notready && f_cnt != '0));
    // R3: a control word never raises occupancy
    a_r3_ctrl_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_in |=> f_cnt <= $past(f_cnt));
    // R7: overflow is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R5: an accepted payload word consumes the pending sync mark
    a_r5_sync_used: assert property (@(posedge clk) disable iff (!rst_n)
        (data_in && !f_drop && !ctrl_in) |=> !t_q.sync_pend);
endmodule

// File: tb/lnk_rx_flow_test.sv
module lnk_rx_flow_test;
    localparam int DW = 16;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic lnk_valid = 0, lnk_ctrl = 0;
    logic [DW-1:0] lnk_word = '0;
    logic dn_suspend = 0, dn_notready = 0;
    logic [CW-1:0] cfg_hi = CW'(10), cfg_lo = CW'(4);
    logic [DW-1:0] px_data;
    logic px_valid, px_sync, sb_notready, sb_dir, backoff, overflow;
    logic [1:0] sb_gp;

    int checks = 0, fails = 0;
    logic [DW:0] q[$];
    logic pend_sync = 0;
    logic [DW-1:0] seq = 16'h0100;

    lnk_rx_flow #(.DW(DW), .DEPTH(DEPTH)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        lnk_valid = 0;
        lnk_ctrl  = 0;
    endtask

    task automatic send_data(input logic [DW-1:0] d, input logic expect_keep);
        lnk_valid = 1; lnk_ctrl = 0; lnk_word = d;
        if (expect_keep) begin
            q.push_back({pend_sync, d});
            pend_sync = 0;
        end
        tick();
    endtask

    task automatic send_ctrl(input logic [4:0] f);
        lnk_valid = 1; lnk_ctrl = 1; lnk_word = DW'(f);
        if (f[2]) pend_sync = 1;
        tick();
    endtask

    // scoreboard monitor, R1 R2 R5
    always @(negedge clk) begin
        if (rst_n && px_valid) begin
            chk(!dn_suspend && !dn_notready, "R2 strobe while held", 1, 0);
            if (q.size() == 0) begin
                chk(0, "R1 unexpected word", int'(px_data), -1);
            end else begin
                logic [DW:0] e;
                e = q.pop_front();
                chk(px_data == e[DW-1:0], "R1 order", int'(px_data), int'(e[DW-1:0]));
                chk(px_sync == e[DW], "R5 sync mark", int'(px_sync), int'(e[DW]));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R8 reset state
        chk(!px_valid && !px_sync && !backoff && !overflow, "R8 reset outputs", int'(px_valid), 0);
        chk(!sb_notready && !sb_dir && sb_gp == 0, "R8 reset sideband", int'(sb_gp), 0);

        // R1 streaming with free downstream
        for (int i = 0; i < 8; i++) begin send_data(seq, 1); seq++; end
        repeat (3) tick();
        chk(q.size() == 0, "R1 stream drained", q.size(), 0);

        // R3 R4 sideband bypasses queued data
        dn_suspend = 1;
        send_data(seq, 1); seq++;
        send_data(seq, 1); seq++;
        send_ctrl(5'b10011);
        chk(sb_notready == 1 && sb_dir == 1 && sb_gp == 2'b10, "R4 sideband update", int'(sb_gp), 2);
        chk(!px_valid, "R2 held by suspend", int'(px_valid), 0);
        chk(q.size() == 2, "R3 ctrl word not stored", q.size(), 2);
        send_ctrl(5'b01000);
        chk(sb_notready == 0 && sb_dir == 0 && sb_gp == 2'b01, "R4 sideband second", int'(sb_gp), 1);
        dn_suspend = 0;
        dn_notready = 1;
        tick();
        chk(!px_valid, "R2 held by notready", int'(px_valid), 0);
        dn_notready = 0;
        repeat (3) tick();
        chk(q.size() == 0, "R3 only two data out", q.size(), 0);

        // R5 sync marks the next data word
        send_ctrl(5'b00100);
        send_ctrl(5'b00100);
        send_data(seq, 1); seq++;
        send_data(seq, 1); seq++;
        repeat (3) tick();

        // R6 back-off hysteresis, independent of dn_suspend
        dn_suspend = 1;
        tick();
        chk(!backoff, "R6 no back-off from dn_suspend", int'(backoff), 0);
        for (int i = 0; i < 9; i++) begin send_data(seq, 1); seq++; end
        tick();
        chk(!backoff, "R6 below high mark", int'(backoff), 0);
        send_data(seq, 1); seq++;
        tick();
        chk(backoff, "R6 at high mark", int'(backoff), 1);
        for (int i = 0; i < 6; i++) begin
            dn_suspend = 0; tick(); dn_suspend = 1;
        end
        tick();
        chk(backoff, "R6 hold at low mark", int'(backoff), 1);
        dn_suspend = 0; tick(); dn_suspend = 1;
        tick();
        chk(!backoff, "R6 below low mark", int'(backoff), 0);

        // R7 overflow: 3 stored, fill to DEPTH then one more
        for (int i = 0; i < DEPTH - 3; i++) begin send_data(seq, 1); seq++; end
        chk(!overflow, "R7 no overflow when exactly full", int'(overflow), 0);
        send_data(16'hDEAD, 0);
        chk(overflow, "R7 overflow set", int'(overflow), 1);
        dn_suspend = 0;
        for (int i = 0; i < 40 && q.size() != 0; i++) tick();
        tick();
        chk(q.size() == 0 && !px_valid, "R7 dropped word absent", q.size(), 0);
        chk(overflow, "R7 overflow sticky", int'(overflow), 1);

        // random suspend / not-ready with sync marks
        for (int i = 0; i < 400; i++) begin
            dn_suspend  = ($urandom_range(0, 2) == 0);
            dn_notready = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 5) == 0) send_ctrl(5'($urandom_range(0, 31)));
            else if (q.size() < DEPTH - 2 && $urandom_range(0, 1) == 1) begin
                send_data(seq, 1); seq++;
            end else tick();
        end
        dn_suspend = 0; dn_notready = 0;
        for (int i = 0; i < 40 && q.size() != 0; i++) tick();
        tick();
        chk(q.size() == 0, "R1 random phase drained", q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule